// File: doc/BRIEF.md
# Opcode-to-Control Decoder for a One-Cycle Load/Store Core

This block turns the 6-bit primary opcode of the instruction being executed into the steering and enable lines of a one-cycle load/store datapath. It has no clock and no state, so the settled outputs follow the opcode within the same cycle. It drives seven single-bit lines and a 2-bit ALU class. The ALU class goes to a separate function decoder, which is not part of this block.

The logic is a two-level product/sum structure. The first level is an AND plane with one match term per supported instruction; all register-to-register instructions share a single term. The second level is an OR plane in which each output collects the match terms whose table entry holds a 1. Table entries that the datapath ignores are fixed at 0, so every opcode has exactly one output pattern. An opcode that matches no term raises an illegal-opcode flag and leaves every enable low.

Top module: `opdec_top`

## Requirements
- R1: Opcode 000000 (register-to-register class) gives dst_rd_sel=1, opb_imm=0, wb_mem=0, rf_wen=1, dmem_rd=0, dmem_wr=0, br_eq=0, alu_class=10, bad_op=0.
- R2: Opcode 100011 (load word) gives dst_rd_sel=0, opb_imm=1, wb_mem=1, rf_wen=1, dmem_rd=1, dmem_wr=0, br_eq=0, alu_class=00, bad_op=0.
- R3: Opcode 101011 (store word) gives opb_imm=1, rf_wen=0, dmem_rd=0, dmem_wr=1, br_eq=0, alu_class=00, bad_op=0, and its unused lines dst_rd_sel and wb_mem are 0.
- R4: Opcode 000100 (branch if equal) gives opb_imm=0, rf_wen=0, dmem_rd=0, dmem_wr=0, br_eq=1, alu_class=01, bad_op=0, and its unused lines dst_rd_sel and wb_mem are 0.
- R5: Each of the other 60 opcodes gives bad_op=1 and drives all seven single-bit lines and alu_class to 0.
- R6: dmem_rd and dmem_wr are never 1 together, and dmem_wr is never 1 together with rf_wen.
- R7: br_eq=1 implies rf_wen=0, dmem_rd=0 and dmem_wr=0.
- R8: The outputs depend only on the current opcode. A change of opcode part-way through a clock period shows at the outputs within that period, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field of the current instruction |
| dst_rd_sel | output | 1 | Destination register taken from the third register field |
| opb_imm | output | 1 | ALU second operand is the sign-extended immediate |
| wb_mem | output | 1 | Register write-back data comes from data memory |
| rf_wen | output | 1 | Register file write enable |
| dmem_rd | output | 1 | Data memory read enable |
| dmem_wr | output | 1 | Data memory write enable |
| br_eq | output | 1 | Instruction is a branch taken on operand equality |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract/compare, 10 use function field |
| bad_op | output | 1 | Opcode matches no supported instruction |

## Verification
The block holds no state, so an internal fault can only be a wrong match term or a wrong OR-plane column. Such a fault appears at the ports in the same cycle as the affected opcode and shows nowhere else. Sweeping all 64 opcodes therefore exposes any bad product term or column. A match term that is too wide shows up on some neighbouring illegal opcode as a missing bad_op or as a stray enable. The mid-cycle opcode change exposes any state that has been added by mistake.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OP_W   = 6;
  localparam int N_CLS  = 4;
  localparam int N_CTL  = 9;

  // Instruction class indices (one AND-plane term each)
  localparam int CLS_REG   = 0;
  localparam int CLS_LOAD  = 1;
  localparam int CLS_STORE = 2;
  localparam int CLS_BEQ   = 3;

  // Column positions in the control word
  localparam int COL_DST  = 0;
  localparam int COL_IMM  = 1;
  localparam int COL_WBM  = 2;
  localparam int COL_RFW  = 3;
  localparam int COL_MRD  = 4;
  localparam int COL_MWR  = 5;
  localparam int COL_BR   = 6;
  localparam int COL_AC0  = 7;
  localparam int COL_AC1  = 8;

  typedef struct packed {
    logic [1:0] alu_class;
    logic       br_eq;
    logic       dmem_wr;
    logic       dmem_rd;
    logic       rf_wen;
    logic       wb_mem;
    logic       opb_imm;
    logic       dst_rd_sel;
  } ctl_word_t;

  function automatic logic [OP_W-1:0] code_of(input int cls);
    case (cls)
      CLS_REG:   code_of = 6'b000000;
      CLS_LOAD:  code_of = 6'b100011;
      CLS_STORE: code_of = 6'b101011;
      default:   code_of = 6'b000100;
    endcase
  endfunction

  // Fixed control table row; unused entries pinned to 0.
  function automatic logic [N_CTL-1:0] row_of(input int cls);
    case (cls)
      CLS_REG:   row_of = 9'b10_0_0_0_1_0_0_1;
      CLS_LOAD:  row_of = 9'b00_0_0_1_1_1_1_0;
      CLS_STORE: row_of = 9'b00_0_1_0_0_0_1_0;
      default:   row_of = 9'b01_1_0_0_0_0_0_0;
    endcase
  endfunction

  // Which classes set a given column: the OR-plane connection mask.
  function automatic logic [N_CLS-1:0] col_mask(input int col);
    logic [N_CTL-1:0] r;
    col_mask = '0;
    for (int k = 0; k < N_CLS; k++) begin
      r = row_of(k);
      col_mask[k] = r[col];
    end
  endfunction
endpackage

// File: rtl/opdec_and_plane.sv
module opdec_and_plane #(
  parameter int OPW  = opdec_pkg::OP_W,
  parameter int NCLS = opdec_pkg::N_CLS
) (
  input  logic [OPW-1:0]  op,
  output logic [NCLS-1:0] hit
);
  for (genvar g = 0; g < NCLS; g++) begin : g_term
    logic [OPW-1:0] lit_ok;
    always_comb begin
      lit_ok = ~(op ^ opdec_pkg::code_of(g));
      hit[g] = &lit_ok;
    end
  end

  // R5
  always_comb begin
    term_onehot_chk: assert ($onehot0(hit))
      else $error("more than one instruction term active");
  end
endmodule

// File: rtl/opdec_or_plane.sv
module opdec_or_plane #(
  parameter int NCLS = opdec_pkg::N_CLS,
  parameter int NCTL = opdec_pkg::N_CTL
) (
  input  logic [NCLS-1:0] hit,
  output logic [NCTL-1:0] ctl
);
  for (genvar c = 0; c < NCTL; c++) begin : g_col
    localparam logic [NCLS-1:0] MASK = opdec_pkg::col_mask(c);
    always_comb ctl[c] = |(hit & MASK);
  end

  // R5
  always_comb begin
    idle_plane_chk: assert (hit != '0 || ctl == '0)
      else $error("control asserted without any term");
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top (
  input  logic [5:0] opcode,
  output logic       dst_rd_sel,
  output logic       opb_imm,
  output logic       wb_mem,
  output logic       rf_wen,
  output logic       dmem_rd,
  output logic       dmem_wr,
  output logic       br_eq,
  output logic [1:0] alu_class,
  output logic       bad_op
);
  import opdec_pkg::*;

  logic [N_CLS-1:0] term_hit;
  logic [N_CTL-1:0] ctl_bits;
  ctl_word_t        cw;

  opdec_and_plane #(.OPW(OP_W), .NCLS(N_CLS)) u_and (
    .op  (opcode),
    .hit (term_hit)
  );

  opdec_or_plane #(.NCLS(N_CLS), .NCTL(N_CTL)) u_or (
    .hit (term_hit),
    .ctl (ctl_bits)
  );

  always_comb begin
    cw         = ctl_word_t'(ctl_bits);
    dst_rd_sel = cw.dst_rd_sel;
    opb_imm    = cw.opb_imm;
    wb_mem     = cw.wb_mem;
    rf_wen     = cw.rf_wen;
    dmem_rd    = cw.dmem_rd;
    dmem_wr    = cw.dmem_wr;
    br_eq      = cw.br_eq;
    alu_class  = cw.alu_class;
    bad_op     = ~|term_hit;
  end

  always_comb begin
    // R6
    mem_excl_chk: assert (!(dmem_rd && dmem_wr))
      else $error("read and write to data memory together");
    // R6
    store_nowb_chk: assert (!(dmem_wr && rf_wen))
      else $error("store with register write");
    // R7
    branch_quiet_chk: assert (!br_eq || !(rf_wen || dmem_rd || dmem_wr))
      else $error("branch with a write or memory enable");
    // R5
    bad_quiet_chk: assert (!bad_op || {rf_wen, dmem_rd, dmem_wr, br_eq} == 4'b0)
      else $error("illegal opcode drives enables");
    // R2
    load_path_chk: assert (!dmem_rd || (wb_mem && rf_wen && opb_imm))
      else $error("memory read without load write-back path");
  end
endmodule

// File: tb/opdec_top_tb.sv
module opdec_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] opcode;
  logic dst_rd_sel, opb_imm, wb_mem, rf_wen, dmem_rd, dmem_wr, br_eq, bad_op;
  logic [1:0] alu_class;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  opdec_top u_dut (
    .opcode(opcode), .dst_rd_sel(dst_rd_sel), .opb_imm(opb_imm),
    .wb_mem(wb_mem), .rf_wen(rf_wen), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .br_eq(br_eq), .alu_class(alu_class), .bad_op(bad_op)
  );

  // Observed word: {bad, class[1:0], br, mwr, mrd, rfw, wbm, imm, dst}
  function automatic logic [9:0] seen();
    return {bad_op, alu_class, br_eq, dmem_wr, dmem_rd, rf_wen, wb_mem, opb_imm, dst_rd_sel};
  endfunction

  // Directed vectors: {opcode, expected word}
  localparam logic [15:0] VEC [4] = '{
    {6'b000000, 10'b0_10_0_0_0_1_0_0_1},   // R1
    {6'b100011, 10'b0_00_0_0_1_1_1_1_0},   // R2
    {6'b101011, 10'b0_00_0_1_0_0_0_1_0},   // R3
    {6'b000100, 10'b0_01_1_0_0_0_0_0_0}    // R4
  };

  // Independent reference written as a decision list
  function automatic logic [9:0] ref_word(input logic [5:0] op);
    logic [9:0] w;
    w = 10'b1_00_0_0_0_0_0_0_0;
    if (op == 6'd0)  w = 10'b0100001001;
    if (op == 6'd35) w = 10'b0000011110;
    if (op == 6'd43) w = 10'b0000100010;
    if (op == 6'd4)  w = 10'b0011000000;
    return w;
  endfunction

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'd0:    return "R1";
      6'd35:   return "R2";
      6'd43:   return "R3";
      6'd4:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: opcode=%b actual=%b expected=%b", req, opcode, act, exp);
    end
  endtask

  initial begin
    opcode = 6'b000000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset with opcode held at zero
    check("R1", seen(), 10'b0100001001);

    foreach (VEC[i]) begin
      @(posedge clk);
      opcode = VEC[i][15:10];
      @(negedge clk);
      check(tag_of(VEC[i][15:10]), seen(), VEC[i][9:0]);
    end

    for (int k = 0; k < 64; k++) begin
      @(posedge clk);
      opcode = 6'(k);
      @(negedge clk);
      check(tag_of(6'(k)), seen(), ref_word(6'(k)));
      // R6 R7: exclusivity seen at the ports
      n_tests++;
      if ((dmem_rd && dmem_wr) || (dmem_wr && rf_wen) ||
          (br_eq && (rf_wen || dmem_rd || dmem_wr))) begin
        n_fail++;
        $display("FAIL R6/R7: opcode=%b actual=%b expected=no conflicting enables", opcode, seen());
      end
    end

    // R5: neighbours of legal codes, one bit off
    for (int b = 0; b < 6; b++) begin
      @(posedge clk);
      opcode = 6'b100011 ^ 6'(1 << b);
      @(negedge clk);
      check("R5", seen(), ref_word(opcode));
    end

    // R8: mid-period change, no clock edge between
    @(posedge clk);
    opcode = 6'b000100;
    #1;
    check("R8", seen(), 10'b0011000000);
    opcode = 6'b101011;
    #1;
    check("R8", seen(), 10'b0000100010);
    opcode = 6'b111111;
    #1;
    check("R8", seen(), 10'b1000000000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule